// File: doc/BRIEF.md
# Cycle Counter with Selectable Overflow Width

This block keeps a 64-bit running count of processor cycles for a performance-monitoring unit. Each clock, an increment strobe with an amount may add to the count. The addition happens only when three things hold: the master enable in the control register is on, the counter's own enable input is high, and the privilege filter register lets the present privilege level count. Software can load the whole count with a 64-bit write, or replace only its lower half with a 32-bit write. A control-register write with the reset bit set clears the count.

The block raises a one-cycle overflow pulse when an increment carries out of the chosen overflow bit. That bit is 63 in long-counter mode and 31 otherwise. The pulse is meant to be captured as a sticky flag by the status register that sits beside this block. In the control register only the enable and a few storage bits can be written. The long-counter bit is set at build time by a parameter. The upper byte holds an implementer code and bits 15:11 report the number of event counters.

Top module: `cyc_count_unit`

## Requirements
- R1: After reset the count is 0, the overflow pulse is low and the filter reads 0. The control register reads `{IMPL_CODE, 8'h00, NUM_EVT[4:0], 11'h0}` with bit 6 equal to `LONG_CNT`. With defaults (IMPL_CODE 0x5A, 4 counters) that is 0x5A002000, or 0x5A002040 when LONG_CNT=1.
- R2: A control write with bit 2 set makes the count 0 on the next edge. This wins over a counter write or an increment in the same cycle. Bit 2 itself is not stored and reads 0.
- R3: A control write changes only bits 0, 3, 4 and 5 (mask 0x39). Every other control bit keeps its value.
- R4: When the increment strobe is high and counting is allowed, the count grows by the amount on the next edge. Counting is allowed when control bit 0 is 1, the enable input is 1 and the filter passes the privilege level.
- R5: The filter works per privilege level. Level 0 is blocked when filter bit 30 is 1. Level 1 is blocked when bit 31 is 1. Level 2 counts only when bit 27 is 1. Level 3 always passes.
- R6: A filter write stores only bits 31:26 of the data. Bits 25:0 read 0.
- R7: An increment that takes the overflow bit from 1 to 0 pulses the overflow output for exactly the one cycle in which the new count is shown. The overflow bit is 63 when control bit 6 is 1 and 31 when it is 0. Counter writes never pulse it.
- R8: A 64-bit write loads the whole count. A 32-bit write replaces bits 31:0 and keeps bits 63:32. Both take effect whatever the gating is, and both win over an increment in the same cycle.
- R9: With control bit 0 at 0, or the enable input low, an increment strobe leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Increment strobe |
| tick_amt_i | input | AMT_W | Amount to add on a strobe |
| priv_i | input | 2 | Current privilege level, 0 to 3 |
| cnt_en_i | input | 1 | Counter enable bit from the enable-set register |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write data |
| flt_we_i | input | 1 | Filter register write strobe |
| flt_wdata_i | input | 32 | Filter register write data |
| cnt_we_i | input | 1 | Full-width counter write strobe |
| cnt_lo_we_i | input | 1 | Low-half counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write data |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |
| ctl_o | output | 32 | Control register read value |
| flt_o | output | 32 | Filter register read value |

## Verification
Every result here is due one edge after its stimulus: the count, the overflow pulse and both register reads are registered, with no other stage in between. The bench drives inputs on a falling edge and reads outputs on the next falling edge, half a cycle after the rising edge that updates them. It then reads once more a full cycle later to confirm the overflow pulse has dropped. Same-cycle conflicts (clear against write against increment) are driven together in a single cycle, so the priority order is seen in one result.

// File: rtl/cyc_pkg.sv
package cyc_pkg;
   // control register bit positions
   localparam int CTL_EN  = 0;
   localparam int CTL_CLR = 2;
   localparam int CTL_LC  = 6;
   localparam int CTL_NEV_LSB = 11;
   localparam logic [31:0] CTL_WMASK = 32'h0000_0039;
   // filter register bit positions
   localparam int FLT_KERN_OFF = 31;
   localparam int FLT_USER_OFF = 30;
   localparam int FLT_HYP_ON   = 27;
   localparam logic [31:0] FLT_WMASK = 32'hFC00_0000;

   typedef enum logic [1:0] {
      PRIV_USER = 2'd0,
      PRIV_KERN = 2'd1,
      PRIV_HYP  = 2'd2,
      PRIV_TOP  = 2'd3
   } priv_e;
endpackage

// File: rtl/cyc_cfg_regs.sv
module cyc_cfg_regs
   import cyc_pkg::*;
#(
   parameter int          NUM_EVT   = 4,
   parameter logic [7:0]  IMPL_CODE = 8'h5A,
   parameter bit          LONG_CNT  = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ctl_we_i,
   input  logic [31:0] ctl_wdata_i,
   input  logic        flt_we_i,
   input  logic [31:0] flt_wdata_i,
   output logic [31:0] ctl_o,
   output logic [31:0] flt_o,
   output logic        clr_o
);
   localparam logic [4:0]  NEV = 5'(NUM_EVT);
   localparam logic [31:0] CTL_RST =
      {IMPL_CODE, 8'h00, NEV, 4'h0, LONG_CNT, 6'h00};

   logic [31:0] ctl_q, flt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
         flt_q <= '0;
      end else begin
         if (ctl_we_i) ctl_q <= (ctl_q & ~CTL_WMASK) | (ctl_wdata_i & CTL_WMASK);
         if (flt_we_i) flt_q <= flt_wdata_i & FLT_WMASK;
      end
   end

   assign clr_o = ctl_we_i & ctl_wdata_i[CTL_CLR];
   assign ctl_o = ctl_q;
   assign flt_o = flt_q;

   // R3: protected control bits never move
   p_ro_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q & ~CTL_WMASK) == (CTL_RST & ~CTL_WMASK));
   // R6: filter holds nothing below bit 26
   p_flt_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      flt_we_i |=> (flt_q & ~FLT_WMASK) == 32'h0);
endmodule

// File: rtl/cyc_gate.sv
module cyc_gate
   import cyc_pkg::*;
(
   input  logic        tick_i,
   input  logic        cnt_en_i,
   input  logic [1:0]  priv_i,
   input  logic [31:0] ctl_i,
   input  logic [31:0] flt_i,
   output logic        inc_o
);
   logic [3:0] lvl_pass;

   // one pass term per privilege level
   for (genvar g = 0; g < 4; g++) begin : g_lvl
      if (g == int'(PRIV_USER)) begin : g_u
         assign lvl_pass[g] = ~flt_i[FLT_USER_OFF];
      end else if (g == int'(PRIV_KERN)) begin : g_k
         assign lvl_pass[g] = ~flt_i[FLT_KERN_OFF];
      end else if (g == int'(PRIV_HYP)) begin : g_h
         assign lvl_pass[g] = flt_i[FLT_HYP_ON];
      end else begin : g_t
         assign lvl_pass[g] = 1'b1;
      end
   end

   assign inc_o = tick_i & cnt_en_i & ctl_i[CTL_EN] & lvl_pass[priv_i];

   // R9: no increment without master enable or counter enable
   always_comb begin
      a_gate_r9: assert (!(inc_o && (!ctl_i[CTL_EN] || !cnt_en_i)));
   end
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
   parameter int CNT_W = 64,
   parameter int LO_W  = 32,
   parameter int AMT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_full_i,
   input  logic             wr_lo_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             inc_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             long_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam int HI_W = CNT_W - LO_W;

   logic [CNT_W-1:0] cnt_q, sum;
   logic             ovf_q, old_top, new_top;

   assign sum     = cnt_q + {{(CNT_W-AMT_W){1'b0}}, amt_i};
   assign old_top = long_i ? cnt_q[CNT_W-1] : cnt_q[LO_W-1];
   assign new_top = long_i ? sum[CNT_W-1]   : sum[LO_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= 1'b0;
         if (clr_i)          cnt_q <= '0;
         else if (wr_full_i) cnt_q <= wdata_i;
         else if (wr_lo_i)   cnt_q <= {cnt_q[CNT_W-1 -: HI_W], wdata_i[LO_W-1:0]};
         else if (inc_i) begin
            cnt_q <= sum;
            ovf_q <= old_top & ~new_top;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> cnt_q == '0);
   p_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clr_i && !wr_full_i && !wr_lo_i)
      |=> cnt_q == $past(cnt_q) + {{(CNT_W-AMT_W){1'b0}}, $past(amt_i)});
   p_ovf_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> !(long_i ? cnt_q[CNT_W-1] : cnt_q[LO_W-1]));
   p_ovf_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i || wr_full_i || wr_lo_i) |=> !ovf_q);
   p_lo_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && !clr_i && !wr_full_i)
      |=> cnt_q[CNT_W-1 -: HI_W] == $past(cnt_q[CNT_W-1 -: HI_W]));
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !wr_full_i && !wr_lo_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/cyc_count_unit.sv
module cyc_count_unit
   import cyc_pkg::*;
#(
   parameter int         CNT_W     = 64,
   parameter int         LO_W      = 32,
   parameter int         AMT_W     = 16,
   parameter int         NUM_EVT   = 4,
   parameter logic [7:0] IMPL_CODE = 8'h5A,
   parameter bit         LONG_CNT  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic [AMT_W-1:0] tick_amt_i,
   input  logic [1:0]       priv_i,
   input  logic             cnt_en_i,
   input  logic             ctl_we_i,
   input  logic [31:0]      ctl_wdata_i,
   input  logic             flt_we_i,
   input  logic [31:0]      flt_wdata_i,
   input  logic             cnt_we_i,
   input  logic             cnt_lo_we_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_o,
   output logic [31:0]      ctl_o,
   output logic [31:0]      flt_o
);
   if (LO_W >= CNT_W) begin : g_bad_lo
      $error("LO_W must be narrower than CNT_W");
   end
   if (AMT_W >= LO_W) begin : g_bad_amt
      $error("AMT_W must be narrower than LO_W");
   end
   if (NUM_EVT < 0 || NUM_EVT > 31) begin : g_bad_nev
      $error("NUM_EVT must fit in five bits");
   end

   logic [31:0] ctl_w, flt_w;
   logic        clr_w, inc_w;

   cyc_cfg_regs #(.NUM_EVT(NUM_EVT), .IMPL_CODE(IMPL_CODE), .LONG_CNT(LONG_CNT)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
      .flt_we_i(flt_we_i), .flt_wdata_i(flt_wdata_i),
      .ctl_o(ctl_w), .flt_o(flt_w), .clr_o(clr_w)
   );

   cyc_gate u_gate (
      .tick_i(tick_i), .cnt_en_i(cnt_en_i), .priv_i(priv_i),
      .ctl_i(ctl_w), .flt_i(flt_w), .inc_o(inc_w)
   );

   cyc_counter #(.CNT_W(CNT_W), .LO_W(LO_W), .AMT_W(AMT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr_i(clr_w), .wr_full_i(cnt_we_i), .wr_lo_i(cnt_lo_we_i),
      .wdata_i(cnt_wdata_i), .inc_i(inc_w), .amt_i(tick_amt_i),
      .long_i(ctl_w[CTL_LC]), .cnt_o(count_o), .ovf_o(ovf_o)
   );

   assign ctl_o = ctl_w;
   assign flt_o = flt_w;

   // R5: a blocked user level never changes the count by ticking alone
   p_user_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_i == 2'd0 && flt_w[FLT_USER_OFF] && !ctl_we_i && !cnt_we_i && !cnt_lo_we_i)
      |=> $stable(count_o));
endmodule

// File: tb/sim_cyc_count_unit.sv
module sim_cyc_count_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [15:0] amt = '0;
   logic [1:0]  priv = 2'd0;
   logic        cen = 1'b0;
   logic        ctl_we = 1'b0, flt_we = 1'b0, cnt_we = 1'b0, lo_we = 1'b0;
   logic [31:0] ctl_wd = '0, flt_wd = '0;
   logic [63:0] cnt_wd = '0;
   logic [63:0] cnt0, cnt1;
   logic        ovf0, ovf1;
   logic [31:0] ctl0, ctl1, flt0, flt1;
   int n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   cyc_count_unit u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .tick_amt_i(amt), .priv_i(priv),
      .cnt_en_i(cen), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
      .flt_we_i(flt_we), .flt_wdata_i(flt_wd), .cnt_we_i(cnt_we),
      .cnt_lo_we_i(lo_we), .cnt_wdata_i(cnt_wd),
      .count_o(cnt0), .ovf_o(ovf0), .ctl_o(ctl0), .flt_o(flt0));

   cyc_count_unit #(.LONG_CNT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .tick_amt_i(amt), .priv_i(priv),
      .cnt_en_i(cen), .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
      .flt_we_i(flt_we), .flt_wdata_i(flt_wd), .cnt_we_i(cnt_we),
      .cnt_lo_we_i(lo_we), .cnt_wdata_i(cnt_wd),
      .count_o(cnt1), .ovf_o(ovf1), .ctl_o(ctl1), .flt_o(flt1));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // each strobe task drives at a falling edge and returns one cycle later
   task automatic wr_ctl(input logic [31:0] v);
      ctl_we = 1'b1; ctl_wd = v; @(negedge clk); ctl_we = 1'b0;
   endtask
   task automatic wr_flt(input logic [31:0] v);
      flt_we = 1'b1; flt_wd = v; @(negedge clk); flt_we = 1'b0;
   endtask
   task automatic wr_cnt(input logic [63:0] v);
      cnt_we = 1'b1; cnt_wd = v; @(negedge clk); cnt_we = 1'b0;
   endtask
   task automatic do_tick(input logic [15:0] a);
      tick = 1'b1; amt = a; @(negedge clk); tick = 1'b0;
   endtask
   task automatic tick_at(input logic [1:0] p, input logic [63:0] exp, input string req);
      priv = p; do_tick(16'd1); chk(req, cnt0, exp);
   endtask

   task automatic t_reset();
      chk("R1 count", cnt0, 64'd0);
      chk("R1 ovf", {63'd0, ovf0}, 64'd0);
      chk("R1 ctl short", {32'd0, ctl0}, 64'h5A00_2000);
      chk("R1 ctl long", {32'd0, ctl1}, 64'h5A00_2040);
      chk("R1 flt", {32'd0, flt0}, 64'd0);
   endtask

   task automatic t_ctl_mask();
      wr_ctl(32'hFFFF_FFFF);
      chk("R3 ctl set short", {32'd0, ctl0}, 64'h5A00_2039);
      chk("R3 ctl set long", {32'd0, ctl1}, 64'h5A00_2079);
      wr_ctl(32'h0000_0000);
      chk("R3 ctl cleared", {32'd0, ctl0}, 64'h5A00_2000);
   endtask

   task automatic t_count();
      wr_ctl(32'h1); cen = 1'b1; priv = 2'd0;
      do_tick(16'd5);
      chk("R4 add 5", cnt0, 64'd5);
      do_tick(16'h100);
      chk("R4 add 0x100", cnt0, 64'h105);
      chk("R4 long twin", cnt1, 64'h105);
   endtask

   task automatic t_gate();
      wr_ctl(32'h0);
      do_tick(16'd7);
      chk("R9 master off", cnt0, 64'h105);
      wr_ctl(32'h1); cen = 1'b0;
      do_tick(16'd7);
      chk("R9 enable low", cnt0, 64'h105);
      cen = 1'b1;
   endtask

   task automatic t_filter();
      wr_flt(32'hFFFF_FFFF);
      chk("R6 flt mask", {32'd0, flt0}, 64'hFC00_0000);
      wr_cnt(64'd0);
      tick_at(2'd0, 64'd0, "R5 user blocked");
      tick_at(2'd1, 64'd0, "R5 kern blocked");
      tick_at(2'd2, 64'd1, "R5 hyp allowed");
      tick_at(2'd3, 64'd2, "R5 top allowed");
      wr_flt(32'h4000_0000);
      tick_at(2'd0, 64'd2, "R5 user off");
      tick_at(2'd1, 64'd3, "R5 kern on");
      tick_at(2'd2, 64'd3, "R5 hyp needs bit27");
      wr_flt(32'h8000_0000);
      tick_at(2'd0, 64'd4, "R5 user on");
      tick_at(2'd1, 64'd4, "R5 kern off");
      wr_flt(32'h0); priv = 2'd0;
   endtask

   task automatic t_write();
      wr_cnt(64'h1234_5678_9ABC_DEF0);
      chk("R8 full write", cnt0, 64'h1234_5678_9ABC_DEF0);
      lo_we = 1'b1; cnt_wd = 64'hFFFF_FFFF_1111_2222; @(negedge clk); lo_we = 1'b0;
      chk("R8 low write", cnt0, 64'h1234_5678_1111_2222);
      cnt_we = 1'b1; cnt_wd = 64'd500; tick = 1'b1; amt = 16'd3;
      @(negedge clk); cnt_we = 1'b0; tick = 1'b0;
      chk("R8 write beats tick", cnt0, 64'd500);
      lo_we = 1'b1; cnt_wd = 64'h10; tick = 1'b1;
      @(negedge clk); lo_we = 1'b0; tick = 1'b0;
      chk("R8 low write beats tick", cnt0, 64'h10);
   endtask

   task automatic t_clear();
      wr_cnt(64'd100);
      ctl_we = 1'b1; ctl_wd = 32'h5; tick = 1'b1; amt = 16'd7;
      @(negedge clk); ctl_we = 1'b0; tick = 1'b0;
      chk("R2 clear beats tick", cnt0, 64'd0);
      chk("R2 clear bit not stored", {32'd0, ctl0}, 64'h5A00_2001);
      ctl_we = 1'b1; ctl_wd = 32'h5; cnt_we = 1'b1; cnt_wd = 64'd99;
      @(negedge clk); ctl_we = 1'b0; cnt_we = 1'b0;
      chk("R2 clear beats write", cnt0, 64'd0);
   endtask

   task automatic t_ovf();
      wr_cnt(64'h7FFF_FFF0);
      do_tick(16'h20);
      chk("R7 bit31 rises no ovf", {63'd0, ovf0}, 64'd0);
      chk("R7 count", cnt0, 64'h8000_0010);
      wr_cnt(64'hFFFF_FFF0);
      do_tick(16'h20);
      chk("R7 short ovf", {63'd0, ovf0}, 64'd1);
      chk("R7 long no ovf at 31", {63'd0, ovf1}, 64'd0);
      chk("R7 count past 32 bits", cnt0, 64'h1_0000_0010);
      @(negedge clk);
      chk("R7 pulse one cycle", {63'd0, ovf0}, 64'd0);
      wr_cnt(64'hFFFF_FFFF_FFFF_FFF0);
      do_tick(16'h20);
      chk("R7 long ovf at 63", {63'd0, ovf1}, 64'd1);
      chk("R7 long wrap", cnt1, 64'h10);
      wr_cnt(64'h8000_0000);
      wr_cnt(64'd0);
      chk("R7 write no ovf", {63'd0, ovf0}, 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl_mask();
      t_count();
      t_gate();
      t_filter();
      t_write();
      t_clear();
      t_ovf();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule